// File: doc/BRIEF.md
# Dual-Port Bus Memory with Debug Output Window

This block is a bus slave that sits behind a small processor in a simulation or bring-up system. It has two independent AHB-Lite slave ports over one shared RAM. The data port reads and writes the RAM and also decodes a small window of output registers. Writing those registers raises a one-cycle strobe that carries a character, a 32-bit word, or a halt request with an exit code. The fetch port can only read, and it returns aligned instruction words from the same RAM.

Each port registers the address phase whenever its HREADY is high and serves that transfer in the following cycle, the data phase. Mapped transfers complete with no wait states. A transfer that decodes to nothing gets the standard two-cycle error response: HREADY low with HRESP high, then HREADY high with HRESP still high. The RAM size and the window base are parameters, and the RAM size must be a power of two.

Top module: `ahb_mem_io_slave`

## Requirements
- R1: A transfer is active only when HTRANS bit 1 is set. NONSEQ (2'b10) and SEQ (2'b11) are served, and IDLE (2'b00) and BUSY (2'b01) cause no write, no strobe and no error.
- R2: Each port captures HTRANS, HWRITE, HSIZE and HADDR on every rising edge where its HREADY output is high. A mapped transfer completes in its data phase with HREADY high and HRESP low, so a read that directly follows a write to the same word returns the new data.
- R3: A data-port RAM write stores 1 << HSIZE bytes (HSIZE 0 = byte, 1 = halfword, 2 = word) starting at HADDR. The byte at HADDR + i is taken from HWDATA[8i+7:8i]. The write is accepted only when HADDR <= MEM_BYTES - 4.
- R4: A data-port RAM read ignores HADDR[1:0] and returns the little-endian 32-bit word at the aligned address. It is accepted when the aligned address is <= MEM_BYTES - 4. HRDATA is zero during write data phases and during both error cycles.
- R5: A write to IO_BASE + 0x00 pulses char_vld_o for its data phase, with char_o equal to HWDATA[7:0].
- R6: A write to IO_BASE + 0x04 pulses word_vld_o for its data phase, with word_o equal to HWDATA.
- R7: A write to IO_BASE + 0x08 pulses exit_vld_o for its data phase, with exit_code_o equal to HWDATA. At most one of the three strobes is high in any cycle.
- R8: Any other active data-port transfer is an error. This covers a write outside the RAM range and the three registers, any read of the window, and a read beyond the RAM. The response is one cycle of HREADY=0/HRESP=1, then one cycle of HREADY=1/HRESP=1.
- R9: After an error completes, HRESP returns to 0 unless the next transfer is itself an error.
- R10: The fetch port returns the aligned word from the shared RAM. A fetch whose aligned address is above MEM_BYTES - 4 gets the two-cycle error response of R8.
- R11: The two ports are independent. Both can transfer in the same cycle, and an error on one port leaves the other port's HREADY and HRESP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d_htrans_i | input | 2 | Data port transfer type |
| d_hwrite_i | input | 1 | Data port write select |
| d_hsize_i | input | 3 | Data port transfer size |
| d_haddr_i | input | 32 | Data port byte address |
| d_hwdata_i | input | 32 | Data port write data |
| d_hready_o | output | 1 | Data port transfer done |
| d_hresp_o | output | 1 | Data port error response |
| d_hrdata_o | output | 32 | Data port read data |
| i_htrans_i | input | 2 | Fetch port transfer type |
| i_haddr_i | input | 32 | Fetch port byte address |
| i_hready_o | output | 1 | Fetch port transfer done |
| i_hresp_o | output | 1 | Fetch port error response |
| i_hrdata_o | output | 32 | Fetch port read data |
| char_vld_o | output | 1 | Character register write strobe |
| char_o | output | 8 | Character written |
| word_vld_o | output | 1 | Word register write strobe |
| word_o | output | 32 | Word written |
| exit_vld_o | output | 1 | Halt request strobe |
| exit_code_o | output | 32 | Exit code written |

## Verification
Each port holds one registered address phase and one error flag. A corrupted phase register shows up in the next cycle: a strobe fires on the wrong register, a read returns a word from the wrong address, or a mapped access reports an error. A stuck error flag shows up as HREADY held low for two cycles, or as HRESP still high one cycle after an error has finished. Both are visible within one or two cycles of the faulty transfer. A wrong byte-lane rotation or lane mask only appears when the word is read back later, so the directed sequences write narrow data and then read the whole word.

// File: rtl/ahb_mem_pkg.sv
`timescale 1ns/1ps
package ahb_mem_pkg;

  localparam logic [31:0] IO_MASK  = 32'hFFFF_FF00;
  localparam logic [7:0]  OFS_CHAR = 8'h00;
  localparam logic [7:0]  OFS_WORD = 8'h04;
  localparam logic [7:0]  OFS_EXIT = 8'h08;

  localparam int unsigned SEL_CHAR = 0;
  localparam int unsigned SEL_WORD = 1;
  localparam int unsigned SEL_EXIT = 2;
  localparam int unsigned SEL_N    = 3;

  typedef struct packed {
    logic        wr;
    logic [2:0]  size;
    logic [31:0] addr;
  } dreq_t;

  // byte lanes touched by a transfer of 1 << size bytes at offset off
  function automatic logic [3:0] lane_mask(input logic [2:0] size, input logic [1:0] off);
    logic [3:0] m;
    case (size)
      3'd0:    m = 4'b0001;
      3'd1:    m = 4'b0011;
      default: m = 4'b1111;
    endcase
    return m << off;
  endfunction

  // moves HWDATA byte i onto lane off+i
  function automatic logic [31:0] rot_lanes(input logic [31:0] d, input logic [1:0] off);
    case (off)
      2'd0:    return d;
      2'd1:    return {d[23:0], d[31:24]};
      2'd2:    return {d[15:0], d[31:16]};
      default: return {d[7:0],  d[31:8]};
    endcase
  endfunction

endpackage

// File: rtl/ahb_phase_ctrl.sv
`timescale 1ns/1ps
module ahb_phase_ctrl #(
  parameter int unsigned PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic [PW-1:0] pay_i,
  input  logic          err_i,
  output logic          vld_o,
  output logic [PW-1:0] pay_o,
  output logic          hready_o,
  output logic          hresp_o,
  output logic          ok_o
);

  logic          vld_q;
  logic [PW-1:0] pay_q;
  logic          err2_q;
  logic          err_first;

  assign err_first = vld_q & err_i & ~err2_q;
  assign hready_o  = ~err_first;
  assign hresp_o   = err_first | err2_q;
  assign ok_o      = vld_q & ~err_i & ~err2_q;
  assign vld_o     = vld_q;
  assign pay_o     = pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      pay_q  <= '0;
      err2_q <= 1'b0;
    end else begin
      err2_q <= err_first;
      if (hready_o) begin
        vld_q <= act_i;
        pay_q <= pay_i;
      end
    end
  end

endmodule

// File: rtl/ahb_io_decode.sv
`timescale 1ns/1ps
module ahb_io_decode
  import ahb_mem_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096,
  parameter logic [31:0] IO_BASE   = 32'h8000_0000
) (
  input  logic             vld_i,
  input  logic             wr_i,
  input  logic [31:0]      addr_i,
  output logic             ram_ok_o,
  output logic [SEL_N-1:0] io_sel_o,
  output logic             err_o
);

  localparam logic [31:0] LAST_WORD = 32'(MEM_BYTES - 4);

  logic win_hit;
  logic ram_wr_ok;
  logic ram_rd_ok;
  logic io_ok;

  assign win_hit   = (addr_i & IO_MASK) == IO_BASE;
  assign ram_wr_ok = addr_i <= LAST_WORD;
  assign ram_rd_ok = {addr_i[31:2], 2'b00} <= LAST_WORD;

  always_comb begin
    io_sel_o           = '0;
    io_sel_o[SEL_CHAR] = win_hit && addr_i[7:0] == OFS_CHAR;
    io_sel_o[SEL_WORD] = win_hit && addr_i[7:0] == OFS_WORD;
    io_sel_o[SEL_EXIT] = win_hit && addr_i[7:0] == OFS_EXIT;
  end

  assign ram_ok_o = wr_i ? ram_wr_ok : ram_rd_ok;
  assign io_ok    = wr_i & (|io_sel_o);
  assign err_o    = vld_i & ~(ram_ok_o | io_ok);

endmodule

// File: rtl/ahb_dual_ram.sv
`timescale 1ns/1ps
module ahb_dual_ram #(
  parameter int unsigned WORDS = 1024,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [3:0]    wbe_i,
  input  logic [IW-1:0] widx_i,
  input  logic [31:0]   wdata_i,
  input  logic [IW-1:0] ridx_a_i,
  output logic [31:0]   rdata_a_o,
  input  logic [IW-1:0] ridx_b_i,
  output logic [31:0]   rdata_b_o
);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [7:0] lane_mem [WORDS];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[k]) lane_mem[widx_i] <= wdata_i[8*k +: 8];
    end

    assign rdata_a_o[8*k +: 8] = lane_mem[ridx_a_i];
    assign rdata_b_o[8*k +: 8] = lane_mem[ridx_b_i];
  end

endmodule

// File: rtl/ahb_mem_io_slave.sv
`timescale 1ns/1ps
module ahb_mem_io_slave
  import ahb_mem_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096,
  parameter logic [31:0] IO_BASE   = 32'h8000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  d_htrans_i,
  input  logic        d_hwrite_i,
  input  logic [2:0]  d_hsize_i,
  input  logic [31:0] d_haddr_i,
  input  logic [31:0] d_hwdata_i,
  output logic        d_hready_o,
  output logic        d_hresp_o,
  output logic [31:0] d_hrdata_o,
  input  logic [1:0]  i_htrans_i,
  input  logic [31:0] i_haddr_i,
  output logic        i_hready_o,
  output logic        i_hresp_o,
  output logic [31:0] i_hrdata_o,
  output logic        char_vld_o,
  output logic [7:0]  char_o,
  output logic        word_vld_o,
  output logic [31:0] word_o,
  output logic        exit_vld_o,
  output logic [31:0] exit_code_o
);

  localparam int unsigned WORDS     = MEM_BYTES / 4;
  localparam int unsigned IW        = $clog2(WORDS);
  localparam int unsigned DPW       = $bits(dreq_t);
  localparam logic [31:0] LAST_WORD = 32'(MEM_BYTES - 4);

  // data port
  logic             d_vld, d_ok, d_err, d_ram_ok, d_wr_commit;
  logic [DPW-1:0]   d_pay;
  dreq_t            d_req, d_aph;
  logic [SEL_N-1:0] d_sel;
  logic [31:0]      d_ram_rdata;

  assign d_aph = '{wr: d_hwrite_i, size: d_hsize_i, addr: d_haddr_i};

  ahb_phase_ctrl #(.PW(DPW)) u_d_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (d_htrans_i[1]),
    .pay_i    (d_aph),
    .err_i    (d_err),
    .vld_o    (d_vld),
    .pay_o    (d_pay),
    .hready_o (d_hready_o),
    .hresp_o  (d_hresp_o),
    .ok_o     (d_ok)
  );

  assign d_req = dreq_t'(d_pay);

  ahb_io_decode #(.MEM_BYTES(MEM_BYTES), .IO_BASE(IO_BASE)) u_d_dec (
    .vld_i    (d_vld),
    .wr_i     (d_req.wr),
    .addr_i   (d_req.addr),
    .ram_ok_o (d_ram_ok),
    .io_sel_o (d_sel),
    .err_o    (d_err)
  );

  // fetch port, read only
  logic        f_vld, f_ok, f_err;
  logic [31:0] f_addr;
  logic [31:0] f_ram_rdata;

  ahb_phase_ctrl #(.PW(32)) u_i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (i_htrans_i[1]),
    .pay_i    (i_haddr_i),
    .err_i    (f_err),
    .vld_o    (f_vld),
    .pay_o    (f_addr),
    .hready_o (i_hready_o),
    .hresp_o  (i_hresp_o),
    .ok_o     (f_ok)
  );

  assign f_err = f_vld & ({f_addr[31:2], 2'b00} > LAST_WORD);

  // shared RAM
  assign d_wr_commit = d_ok & d_req.wr & d_ram_ok;

  ahb_dual_ram #(.WORDS(WORDS)) u_ram (
    .clk_i     (clk_i),
    .we_i      (d_wr_commit),
    .wbe_i     (lane_mask(d_req.size, d_req.addr[1:0])),
    .widx_i    (d_req.addr[IW+1:2]),
    .wdata_i   (rot_lanes(d_hwdata_i, d_req.addr[1:0])),
    .ridx_a_i  (d_req.addr[IW+1:2]),
    .rdata_a_o (d_ram_rdata),
    .ridx_b_i  (f_addr[IW+1:2]),
    .rdata_b_o (f_ram_rdata)
  );

  assign d_hrdata_o = (d_ok && !d_req.wr) ? d_ram_rdata : 32'h0;
  assign i_hrdata_o = f_ok ? f_ram_rdata : 32'h0;

  // output register strobes, live for the data phase only
  assign char_vld_o  = d_ok & d_req.wr & d_sel[SEL_CHAR];
  assign word_vld_o  = d_ok & d_req.wr & d_sel[SEL_WORD];
  assign exit_vld_o  = d_ok & d_req.wr & d_sel[SEL_EXIT];
  assign char_o      = d_hwdata_i[7:0];
  assign word_o      = d_hwdata_i;
  assign exit_code_o = d_hwdata_i;

endmodule

// File: rtl/ahb_mem_io_slave_chk.sv
`timescale 1ns/1ps
module ahb_mem_io_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  d_htrans_i,
  input logic [1:0]  i_htrans_i,
  input logic        d_hready_o,
  input logic        d_hresp_o,
  input logic [31:0] d_hrdata_o,
  input logic        i_hready_o,
  input logic        i_hresp_o,
  input logic [31:0] i_hrdata_o,
  input logic        char_vld_o,
  input logic        word_vld_o,
  input logic        exit_vld_o
);

  p_d_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_hready_o && d_htrans_i inside {2'b00, 2'b01}) |=>
      (d_hready_o && !d_hresp_o && !char_vld_o && !word_vld_o && !exit_vld_o));

  p_i_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_hready_o && i_htrans_i inside {2'b00, 2'b01}) |=> (i_hready_o && !i_hresp_o));

  p_err_rdata_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_hresp_o |-> d_hrdata_o == 32'h0);

  p_strobe_okay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_o || word_vld_o || exit_vld_o) |-> (d_hready_o && !d_hresp_o));

  p_strobe_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({char_vld_o, word_vld_o, exit_vld_o}));

  p_err_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !d_hready_o |-> d_hresp_o);

  p_err_second_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !d_hready_o |=> (d_hready_o && d_hresp_o));

  p_okay_return_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_hready_o && d_hresp_o) |=> (!d_hresp_o || !d_hready_o));

  p_fetch_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !i_hready_o |=> (i_hready_o && i_hresp_o));

  p_fetch_rdata_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_hresp_o |-> i_hrdata_o == 32'h0);

endmodule

bind ahb_mem_io_slave ahb_mem_io_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .d_htrans_i (d_htrans_i),
  .i_htrans_i (i_htrans_i),
  .d_hready_o (d_hready_o),
  .d_hresp_o  (d_hresp_o),
  .d_hrdata_o (d_hrdata_o),
  .i_hready_o (i_hready_o),
  .i_hresp_o  (i_hresp_o),
  .i_hrdata_o (i_hrdata_o),
  .char_vld_o (char_vld_o),
  .word_vld_o (word_vld_o),
  .exit_vld_o (exit_vld_o)
);

// File: tb/ahb_mem_io_slave_tb.sv
`timescale 1ns/1ps
module ahb_mem_io_slave_tb_top;

  localparam int unsigned MEM_BYTES = 4096;
  localparam logic [31:0] IOB = 32'h8000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  d_htrans_i = 2'b00;
  logic        d_hwrite_i = 1'b0;
  logic [2:0]  d_hsize_i = 3'd2;
  logic [31:0] d_haddr_i = '0;
  logic [31:0] d_hwdata_i = '0;
  logic        d_hready_o, d_hresp_o;
  logic [31:0] d_hrdata_o;
  logic [1:0]  i_htrans_i = 2'b00;
  logic [31:0] i_haddr_i = '0;
  logic        i_hready_o, i_hresp_o;
  logic [31:0] i_hrdata_o;
  logic        char_vld_o, word_vld_o, exit_vld_o;
  logic [7:0]  char_o;
  logic [31:0] word_o, exit_code_o;

  int checks = 0;
  int fails  = 0;

  logic       s_char, s_word, s_exit;
  logic [7:0] s_char_d;
  logic [31:0] s_word_d, s_exit_d;

  always #2.5 clk_i = ~clk_i;

  ahb_mem_io_slave #(.MEM_BYTES(MEM_BYTES), .IO_BASE(IOB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_htrans_i(d_htrans_i), .d_hwrite_i(d_hwrite_i), .d_hsize_i(d_hsize_i),
    .d_haddr_i(d_haddr_i), .d_hwdata_i(d_hwdata_i),
    .d_hready_o(d_hready_o), .d_hresp_o(d_hresp_o), .d_hrdata_o(d_hrdata_o),
    .i_htrans_i(i_htrans_i), .i_haddr_i(i_haddr_i),
    .i_hready_o(i_hready_o), .i_hresp_o(i_hresp_o), .i_hrdata_o(i_hrdata_o),
    .char_vld_o(char_vld_o), .char_o(char_o),
    .word_vld_o(word_vld_o), .word_o(word_o),
    .exit_vld_o(exit_vld_o), .exit_code_o(exit_code_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one data-port transfer; samples in its data phase
  task automatic d_xfer(input logic [1:0] tr, input bit wr, input logic [2:0] sz,
                        input logic [31:0] addr, input logic [31:0] wd,
                        input bit exp_err, input bit chk_rd, input logic [31:0] exp_rd,
                        input string req);
    @(negedge clk_i);
    d_htrans_i = tr; d_hwrite_i = wr; d_hsize_i = sz; d_haddr_i = addr;
    @(negedge clk_i);
    d_htrans_i = 2'b00; d_hwrite_i = 1'b0; d_hwdata_i = wd;
    #1;
    s_char = char_vld_o; s_char_d = char_o;
    s_word = word_vld_o; s_word_d = word_o;
    s_exit = exit_vld_o; s_exit_d = exit_code_o;
    if (exp_err) begin
      chk(!d_hready_o && d_hresp_o, {req, " err cycle 1"}, {30'd0, d_hready_o, d_hresp_o}, 32'h1);
      chk(d_hrdata_o == 0, {req, " rdata zero in error"}, d_hrdata_o, 32'h0);
      @(negedge clk_i); #1;
      chk(d_hready_o && d_hresp_o, {req, " err cycle 2"}, {30'd0, d_hready_o, d_hresp_o}, 32'h3);
      @(negedge clk_i); #1;
      chk(d_hready_o && !d_hresp_o, "R9 okay after error", {30'd0, d_hready_o, d_hresp_o}, 32'h2);
    end else begin
      chk(d_hready_o && !d_hresp_o, {req, " okay response"}, {30'd0, d_hready_o, d_hresp_o}, 32'h2);
      if (chk_rd) chk(d_hrdata_o == exp_rd, {req, " read data"}, d_hrdata_o, exp_rd);
    end
  endtask

  task automatic i_fetch(input logic [31:0] addr, input bit exp_err, input bit chk_rd,
                         input logic [31:0] exp_rd, input string req);
    @(negedge clk_i);
    i_htrans_i = 2'b10; i_haddr_i = addr;
    @(negedge clk_i);
    i_htrans_i = 2'b00;
    #1;
    if (exp_err) begin
      chk(!i_hready_o && i_hresp_o, {req, " fetch err cycle 1"}, {30'd0, i_hready_o, i_hresp_o}, 32'h1);
      chk(d_hready_o && !d_hresp_o, "R11 data port unaffected", {30'd0, d_hready_o, d_hresp_o}, 32'h2);
      @(negedge clk_i); #1;
      chk(i_hready_o && i_hresp_o, {req, " fetch err cycle 2"}, {30'd0, i_hready_o, i_hresp_o}, 32'h3);
      @(negedge clk_i); #1;
      chk(i_hready_o && !i_hresp_o, "R10 fetch okay after error", {30'd0, i_hready_o, i_hresp_o}, 32'h2);
    end else begin
      chk(i_hready_o && !i_hresp_o, {req, " fetch okay"}, {30'd0, i_hready_o, i_hresp_o}, 32'h2);
      if (chk_rd) chk(i_hrdata_o == exp_rd, {req, " fetch data"}, i_hrdata_o, exp_rd);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(d_hready_o && !d_hresp_o && d_hrdata_o == 0, "R2 reset data port idle",
        {30'd0, d_hready_o, d_hresp_o}, 32'h2);
    chk(i_hready_o && !i_hresp_o && i_hrdata_o == 0, "R10 reset fetch port idle",
        {30'd0, i_hready_o, i_hresp_o}, 32'h2);
    chk(!char_vld_o && !word_vld_o && !exit_vld_o, "R7 reset no strobes",
        {29'd0, char_vld_o, word_vld_o, exit_vld_o}, 32'h0);
  endtask

  task automatic t_ram_sizes;
    d_xfer(2'b10, 1, 3'd2, 32'h100, 32'h1122_3344, 0, 0, 0, "R3 word write");
    chk(d_hrdata_o == 0, "R4 rdata zero on write", d_hrdata_o, 32'h0);
    d_xfer(2'b10, 0, 3'd2, 32'h100, 0, 0, 1, 32'h1122_3344, "R4 word read");
    d_xfer(2'b10, 1, 3'd0, 32'h101, 32'h0000_00AB, 0, 0, 0, "R3 byte write");
    d_xfer(2'b10, 0, 3'd2, 32'h103, 0, 0, 1, 32'h1122_AB44, "R4 unaligned read after byte write R3");
    d_xfer(2'b10, 1, 3'd1, 32'h102, 32'h0000_BEEF, 0, 0, 0, "R3 half write");
    d_xfer(2'b10, 0, 3'd2, 32'h100, 0, 0, 1, 32'hBEEF_AB44, "R3 half write readback");
  endtask

  task automatic t_trans_types;
    d_xfer(2'b01, 1, 3'd2, 32'h100, 32'hFFFF_FFFF, 0, 0, 0, "R1 BUSY write");
    d_xfer(2'b00, 1, 3'd2, 32'h100, 32'hFFFF_FFFF, 0, 0, 0, "R1 IDLE write");
    d_xfer(2'b10, 0, 3'd2, 32'h100, 0, 0, 1, 32'hBEEF_AB44, "R1 ignored writes left RAM");
    d_xfer(2'b11, 1, 3'd2, 32'h104, 32'hCAFE_F00D, 0, 0, 0, "R1 SEQ write");
    d_xfer(2'b11, 0, 3'd2, 32'h104, 0, 0, 1, 32'hCAFE_F00D, "R1 SEQ read");
    d_xfer(2'b01, 1, 3'd0, IOB, 32'h0000_0041, 0, 0, 0, "R1 BUSY to char reg");
    chk(!s_char, "R1 BUSY gives no strobe", {31'd0, s_char}, 32'h0);
  endtask

  task automatic t_io;
    d_xfer(2'b10, 1, 3'd0, IOB, 32'h4141_4141, 0, 0, 0, "R5 char write");
    chk(s_char && !s_word && !s_exit && s_char_d == 8'h41, "R5 char strobe",
        {21'd0, s_char, s_word, s_exit, s_char_d}, {21'd0, 3'b100, 8'h41});
    d_xfer(2'b10, 1, 3'd2, IOB + 4, 32'hDEAD_BEEF, 0, 0, 0, "R6 word write");
    chk(!s_char && s_word && !s_exit, "R6 word strobe", {29'd0, s_char, s_word, s_exit}, 32'h2);
    chk(s_word_d == 32'hDEAD_BEEF, "R6 word data", s_word_d, 32'hDEAD_BEEF);
    d_xfer(2'b10, 1, 3'd2, IOB + 8, 32'h0000_0007, 0, 0, 0, "R7 exit write");
    chk(!s_char && !s_word && s_exit, "R7 exit strobe", {29'd0, s_char, s_word, s_exit}, 32'h1);
    chk(s_exit_d == 32'h7, "R7 exit code", s_exit_d, 32'h7);
  endtask

  task automatic t_errors;
    d_xfer(2'b10, 1, 3'd2, IOB + 32'h10, 32'h1, 1, 0, 0, "R8 undefined register write");
    chk(!s_char && !s_word && !s_exit, "R8 no strobe on error", {29'd0, s_char, s_word, s_exit}, 32'h0);
    d_xfer(2'b10, 0, 3'd2, IOB, 0, 1, 0, 0, "R8 window read");
    d_xfer(2'b10, 0, 3'd2, MEM_BYTES, 0, 1, 0, 0, "R8 read past RAM");
    d_xfer(2'b10, 1, 3'd0, MEM_BYTES - 2, 32'h55, 1, 0, 0, "R3 byte write above last word");
    d_xfer(2'b10, 1, 3'd2, MEM_BYTES - 4, 32'h0BAD_CAFE, 0, 0, 0, "R3 write at last word");
    d_xfer(2'b10, 0, 3'd2, MEM_BYTES - 1, 0, 0, 1, 32'h0BAD_CAFE, "R4 read last word unaligned");
  endtask

  // back-to-back errors, then a good read right behind them
  task automatic t_err_chain;
    @(negedge clk_i);
    d_htrans_i = 2'b10; d_hwrite_i = 0; d_haddr_i = MEM_BYTES + 8;
    @(negedge clk_i); #1;
    chk(!d_hready_o && d_hresp_o, "R8 chain err A1", {30'd0, d_hready_o, d_hresp_o}, 32'h1);
    @(negedge clk_i);
    d_haddr_i = IOB + 4; // read of window, also an error
    #1;
    chk(d_hready_o && d_hresp_o, "R8 chain err A2", {30'd0, d_hready_o, d_hresp_o}, 32'h3);
    @(negedge clk_i);
    d_haddr_i = 32'h104;
    #1;
    chk(!d_hready_o && d_hresp_o, "R9 second error restarts", {30'd0, d_hready_o, d_hresp_o}, 32'h1);
    @(negedge clk_i); #1;
    chk(d_hready_o && d_hresp_o, "R8 chain err B2", {30'd0, d_hready_o, d_hresp_o}, 32'h3);
    @(negedge clk_i);
    d_htrans_i = 2'b00;
    #1;
    chk(d_hready_o && !d_hresp_o && d_hrdata_o == 32'hCAFE_F00D, "R9 good read after errors",
        d_hrdata_o, 32'hCAFE_F00D);
  endtask

  task automatic t_pipeline;
    @(negedge clk_i);
    d_htrans_i = 2'b10; d_hwrite_i = 1; d_hsize_i = 3'd2; d_haddr_i = 32'h200;
    @(negedge clk_i);
    d_hwdata_i = 32'h5A5A_1234;
    d_hwrite_i = 0;
    #1;
    chk(d_hrdata_o == 0, "R4 rdata zero during write phase", d_hrdata_o, 32'h0);
    @(negedge clk_i);
    d_htrans_i = 2'b00;
    #1;
    chk(d_hready_o && d_hrdata_o == 32'h5A5A_1234, "R2 read right after write", d_hrdata_o, 32'h5A5A_1234);
  endtask

  task automatic t_fetch;
    i_fetch(32'h102, 0, 1, 32'hBEEF_AB44, "R10 aligned fetch");
    i_fetch(MEM_BYTES, 1, 0, 0, "R10 fetch past RAM");
    i_fetch(MEM_BYTES - 4, 0, 1, 32'h0BAD_CAFE, "R10 fetch last word");
  endtask

  task automatic t_both_ports;
    @(negedge clk_i);
    d_htrans_i = 2'b10; d_hwrite_i = 0; d_haddr_i = 32'h104;
    i_htrans_i = 2'b10; i_haddr_i = 32'h100;
    @(negedge clk_i);
    d_htrans_i = 2'b00; i_htrans_i = 2'b00;
    #1;
    chk(d_hrdata_o == 32'hCAFE_F00D, "R11 data read alongside fetch", d_hrdata_o, 32'hCAFE_F00D);
    chk(i_hrdata_o == 32'hBEEF_AB44, "R11 fetch alongside data read", i_hrdata_o, 32'hBEEF_AB44);
    @(negedge clk_i);
    d_htrans_i = 2'b10; d_hwrite_i = 0; d_haddr_i = MEM_BYTES;
    i_htrans_i = 2'b10; i_haddr_i = 32'h104;
    @(negedge clk_i);
    d_htrans_i = 2'b00; i_htrans_i = 2'b00;
    #1;
    chk(!d_hready_o && i_hready_o && !i_hresp_o && i_hrdata_o == 32'hCAFE_F00D,
        "R11 fetch unaffected by data error", i_hrdata_o, 32'hCAFE_F00D);
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #12 t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_ram_sizes();
    t_trans_types();
    t_io();
    t_errors();
    t_err_chain();
    t_pipeline();
    t_fetch();
    t_both_ports();
    repeat (3) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule